// File: doc/BRIEF.md
# Execute-in-place streaming prefetch buffer

This block sits between a 64-bit on-chip read port and a serial flash command sequencer. Processors and other bus masters fetch 32-byte lines through it. The block holds one window of flash contents in a 1 KB buffer, described by a base line and a count of received 64-bit beats. A request whose line lies inside the filled part of the window is answered from the buffer, and no flash traffic results.

A request outside the window starts one read burst at the missed line. The burst length comes from a line-count setting that is written before operation. The requested line goes back to the requester as soon as its four beats have landed. The burst keeps streaming the lines that follow into the buffer, so a later request from any master can hit on them.

A request for a line that the running burst has not reached yet waits for it, and no new command is issued. A request outside the window while a burst is running cancels that burst with an abort pulse and restarts at the new line.

Top module: `xpb_top`

## Requirements
- R1: While reset is held and in the cycle after it, req_ready is 1 and rsp_valid, fl_cmd_valid and fl_abort are 0.
- R2: A request whose line is outside the window raises exactly one flash command. fl_cmd_addr is the request address with its low 5 bits cleared. fl_cmd_beats is four times the effective burst line count.
- R3: The effective burst line count is cfg_burst_lines, except that 0 counts as 1 and any value above 32 counts as 32.
- R4: A request whose line lies inside the window, counting from the base line up to the burst line count, is served with no new flash command. The low 5 bits of the request address are ignored.
- R5: Each request is answered with four 64-bit beats in ascending address order. Beat k carries the sequencer word for byte offset 8k of the line, unchanged. rsp_last is 1 on the fourth beat only.
- R6: The response for the line that caused a miss completes while the same burst is still delivering later beats.
- R7: A request for a window line that has not been received yet waits for its beats. It raises no command and no abort.
- R8: A miss while a burst is still streaming pulses fl_abort for one cycle, together with the new command. The response then carries the new burst's data.
- R9: A miss after the previous burst has finished raises a command and no fl_abort.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid and rsp_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_lines | input | 6 | Burst length in 32-byte lines, set before operation |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block accepts a request |
| req_addr | input | 24 | Byte address of the requested line |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the beat |
| rsp_data | output | 64 | Response beat |
| rsp_last | output | 1 | Last beat of the line |
| fl_cmd_valid | output | 1 | Flash read command present |
| fl_cmd_ready | input | 1 | Sequencer takes the command |
| fl_cmd_addr | output | 24 | Start byte address of the burst |
| fl_cmd_beats | output | 8 | Burst length in 64-bit beats |
| fl_abort | output | 1 | Cancel the running burst (one-cycle pulse) |
| fl_rd_valid | input | 1 | Read beat from the sequencer |
| fl_rd_data | input | 64 | Read beat data |

## Verification
If the base line or the received-beat count goes wrong, hits and misses are misjudged. The first request that lands near the window edge then shows a wrong number of flash commands, or returns data from the wrong address within its four beats. If the fill tracker keeps accepting beats after an abort, the restarted line returns stale words in the very response that follows. If the burst length is handled wrongly, fl_cmd_beats is wrong in the same cycle the command appears. A wrong window span also turns the next request just beyond it into a hit or a miss that the requirements do not allow.

// File: rtl/xpb_pkg.sv
package xpb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WAIT,
    ST_READ,
    ST_RESP
  } xpb_state_e;
endpackage

// File: rtl/xpb_store.sv
module xpb_store #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/xpb_fill.sv
module xpb_fill #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32,
  parameter int BUF_BYTES  = 1024,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BPL        = LINE_BYTES / BEAT_BYTES,
  localparam int BPL_W      = $clog2(BPL),
  localparam int BUF_LINES  = BUF_BYTES / LINE_BYTES,
  localparam int BUF_BEATS  = BUF_BYTES / BEAT_BYTES,
  localparam int LOFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W       = ADDR_W - LOFF_W,
  localparam int IDX_W      = $clog2(BUF_BEATS),
  localparam int CNT_W      = $clog2(BUF_BEATS + 1),
  localparam int LCNT_W     = $clog2(BUF_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LA_W-1:0]   start_line,
  input  logic [LCNT_W-1:0] cfg_lines,
  output logic              win_valid,
  output logic [LA_W-1:0]   base_line,
  output logic [LCNT_W-1:0] span_lines,
  output logic [CNT_W-1:0]  fill_beats,
  output logic              fl_cmd_valid,
  input  logic              fl_cmd_ready,
  output logic [ADDR_W-1:0] fl_cmd_addr,
  output logic [CNT_W-1:0]  fl_cmd_beats,
  output logic              fl_abort,
  input  logic              fl_rd_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);
  logic              streaming;
  logic [LCNT_W-1:0] eff_lines;
  logic [CNT_W-1:0]  span_beats;

  always_comb begin
    if (cfg_lines == '0)                        eff_lines = LCNT_W'(1);
    else if (cfg_lines > LCNT_W'(BUF_LINES))    eff_lines = LCNT_W'(BUF_LINES);
    else                                        eff_lines = cfg_lines;
  end

  assign span_beats   = CNT_W'(span_lines) << BPL_W;
  assign fl_cmd_addr  = {base_line, {LOFF_W{1'b0}}};
  assign fl_cmd_beats = span_beats;
  assign wr_en        = streaming && fl_rd_valid;
  assign wr_idx       = fill_beats[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid    <= 1'b0;
      base_line    <= '0;
      span_lines   <= LCNT_W'(1);
      fill_beats   <= '0;
      fl_cmd_valid <= 1'b0;
      fl_abort     <= 1'b0;
      streaming    <= 1'b0;
    end else begin
      fl_abort <= 1'b0;
      if (start) begin
        win_valid    <= 1'b1;
        base_line    <= start_line;
        span_lines   <= eff_lines;
        fill_beats   <= '0;
        fl_cmd_valid <= 1'b1;
        fl_abort     <= streaming;
        streaming    <= 1'b0;
      end else begin
        if (fl_cmd_valid && fl_cmd_ready) begin
          fl_cmd_valid <= 1'b0;
          streaming    <= 1'b1;
        end
        if (wr_en) begin
          fill_beats <= fill_beats + CNT_W'(1);
          if (fill_beats + CNT_W'(1) == span_beats) streaming <= 1'b0;
        end
      end
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill_beats <= span_beats);
  assert_span_range_R3: assert property (@(posedge clk) disable iff (rst)
    span_lines >= LCNT_W'(1) && span_lines <= LCNT_W'(BUF_LINES));
  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fl_abort |=> !fl_abort);
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    fl_cmd_valid && !fl_cmd_ready |=> fl_cmd_valid && $stable(fl_cmd_addr));
endmodule

// File: rtl/xpb_top.sv
module xpb_top #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32,
  parameter int BUF_BYTES  = 1024,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BPL        = LINE_BYTES / BEAT_BYTES,
  localparam int BPL_W      = $clog2(BPL),
  localparam int BUF_LINES  = BUF_BYTES / LINE_BYTES,
  localparam int BUF_BEATS  = BUF_BYTES / BEAT_BYTES,
  localparam int LOFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W       = ADDR_W - LOFF_W,
  localparam int IDX_W      = $clog2(BUF_BEATS),
  localparam int CNT_W      = $clog2(BUF_BEATS + 1),
  localparam int LCNT_W     = $clog2(BUF_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LCNT_W-1:0] cfg_burst_lines,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              fl_cmd_valid,
  input  logic              fl_cmd_ready,
  output logic [ADDR_W-1:0] fl_cmd_addr,
  output logic [CNT_W-1:0]  fl_cmd_beats,
  output logic              fl_abort,
  input  logic              fl_rd_valid,
  input  logic [DATA_W-1:0] fl_rd_data
);
  import xpb_pkg::*;

  xpb_state_e        state;
  logic [LA_W-1:0]   cur_line;
  logic [BPL_W-1:0]  beat;
  logic              win_valid;
  logic [LA_W-1:0]   base_line;
  logic [LCNT_W-1:0] span_lines;
  logic [CNT_W-1:0]  fill_beats;
  logic [LA_W-1:0]   off_line;
  logic [CNT_W-1:0]  need_beats;
  logic              in_win, covered, start, rd_en, wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              unused_low;

  assign unused_low = ^req_addr[LOFF_W-1:0];
  assign off_line   = cur_line - base_line;
  assign in_win     = win_valid && (cur_line >= base_line) &&
                      (off_line < LA_W'(span_lines));
  assign need_beats = (CNT_W'(off_line[LCNT_W-1:0]) + CNT_W'(1)) << BPL_W;
  assign covered    = fill_beats >= need_beats;
  assign rd_idx     = IDX_W'((CNT_W'(off_line[LCNT_W-1:0]) << BPL_W) + CNT_W'(beat));
  assign req_ready  = (state == ST_IDLE);
  assign start      = (state == ST_LOOK) && !in_win;
  assign rd_en      = (state == ST_READ);

  xpb_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES),
             .BUF_BYTES(BUF_BYTES)) u_fill (
    .clk, .rst, .start, .start_line(cur_line), .cfg_lines(cfg_burst_lines),
    .win_valid, .base_line, .span_lines, .fill_beats,
    .fl_cmd_valid, .fl_cmd_ready, .fl_cmd_addr, .fl_cmd_beats, .fl_abort,
    .fl_rd_valid, .wr_en, .wr_idx
  );

  xpb_store #(.DATA_W(DATA_W), .DEPTH(BUF_BEATS)) u_store (
    .clk, .wr_en, .wr_idx, .wr_data(fl_rd_data),
    .rd_en, .rd_idx, .rd_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_line  <= '0;
      beat      <= '0;
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_line <= req_addr[ADDR_W-1:LOFF_W];
          state    <= ST_LOOK;
        end
        ST_LOOK: state <= ST_WAIT;
        ST_WAIT: if (covered) begin
          beat  <= '0;
          state <= ST_READ;
        end
        ST_READ: begin
          rsp_valid <= 1'b1;
          rsp_last  <= (beat == BPL_W'(BPL - 1));
          state     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          rsp_last  <= 1'b0;
          if (beat == BPL_W'(BPL - 1)) state <= ST_IDLE;
          else begin
            beat  <= beat + BPL_W'(1);
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);
  assert_no_req_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
  assert_wait_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> in_win);
endmodule

// File: tb/xpb_top_test.sv
module xpb_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_burst_lines = 6'd4;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_last;
  logic        fl_cmd_valid;
  logic        fl_cmd_ready = 1'b1;
  logic [23:0] fl_cmd_addr;
  logic [7:0]  fl_cmd_beats;
  logic        fl_abort;
  logic        fl_rd_valid = 1'b0;
  logic [63:0] fl_rd_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cmd_count = 0, abort_count = 0;
  logic [23:0] last_cmd_addr = '0;
  int last_cmd_beats = 0;
  logic fm_active = 1'b0;
  int fm_left = 0, fm_wait = 0, fm_gap = 0;
  logic [23:0] fm_addr = '0;
  bit toggle_ready = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xpb_top uut (.*);

  function automatic logic [63:0] pat(input logic [23:0] a);
    return {8'hA5, a, 8'h3C, a ^ 24'h00FFFF};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash sequencer model, acts at falling edges
  initial begin
    forever begin
      @(negedge clk);
      fl_rd_valid = 1'b0;
      if (fl_abort === 1'b1) begin
        abort_count++;
        fm_active = 1'b0;
      end
      if (fl_cmd_valid === 1'b1 && fl_cmd_ready) begin
        cmd_count++;
        last_cmd_addr  = fl_cmd_addr;
        last_cmd_beats = int'(fl_cmd_beats);
        fm_addr   = fl_cmd_addr;
        fm_left   = int'(fl_cmd_beats);
        fm_wait   = 2;
        fm_active = 1'b1;
      end else if (fm_active) begin
        if (fm_wait > 0) fm_wait--;
        else begin
          fl_rd_valid = 1'b1;
          fl_rd_data  = pat(fm_addr);
          fm_addr     = fm_addr + 24'd8;
          fm_left--;
          if (fm_left == 0) fm_active = 1'b0;
          fm_wait = fm_gap;
        end
      end
    end
  end

  task automatic read_line(input logic [23:0] a, input string tag);
    logic [23:0] line;
    int k, guard;
    line = {a[23:5], 5'd0};
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    guard = 0;
    while (req_ready !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (k < 4 && guard < 5000) begin
      rsp_ready = toggle_ready ? ~rsp_ready : 1'b1;
      if (rsp_valid === 1'b1 && rsp_ready) begin
        check(rsp_data === pat(line + 24'(8 * k)),
              {tag, " R5 R10 beat data"}, rsp_data, pat(line + 24'(8 * k)));
        check(rsp_last === (k == 3), {tag, " R5 last flag"},
              64'(rsp_last), 64'(k == 3));
        k++;
      end
      @(negedge clk);
      guard++;
    end
    rsp_ready = 1'b1;
    if (guard >= 5000) check(1'b0, {tag, " response timeout"}, 64'(k), 64'd4);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [23:0] addr;
    logic        miss;
    logic [23:0] base;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{24'h001000, 1'b1, 24'h001000},
    '{24'h001020, 1'b0, 24'h001000},
    '{24'h001060, 1'b0, 24'h001000},
    '{24'h001080, 1'b1, 24'h001080},
    '{24'h000FE0, 1'b1, 24'h000FE0},
    '{24'h001015, 1'b0, 24'h000FE0}
  };

  initial begin
    int c0, a0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(req_ready === 1'b1 && rsp_valid === 1'b0 &&
          fl_cmd_valid === 1'b0 && fl_abort === 1'b0, "R1 reset outputs",
          {60'd0, req_ready, rsp_valid, fl_cmd_valid, fl_abort}, 64'h8);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && fl_cmd_valid === 1'b0,
          "R1 after reset", {61'd0, req_ready, rsp_valid, fl_cmd_valid}, 64'h4);

    // table walk: burst of 4 lines, fast flash (R2 R4 R9)
    for (int v = 0; v < 6; v++) begin
      c0 = cmd_count;
      a0 = abort_count;
      toggle_ready = (v % 2 == 1);
      read_line(VEC[v].addr, $sformatf("vec%0d", v));
      check(cmd_count - c0 == int'(VEC[v].miss), "R2 R4 command count",
            64'(cmd_count - c0), 64'(VEC[v].miss));
      if (VEC[v].miss) begin
        check(last_cmd_addr === VEC[v].base, "R2 command address",
              64'(last_cmd_addr), 64'(VEC[v].base));
        check(last_cmd_beats == 16, "R2 command length",
              64'(last_cmd_beats), 64'd16);
      end
      check(abort_count == a0, "R9 no abort after finished burst",
            64'(abort_count - a0), 64'd0);
      idle(40);
    end
    toggle_ready = 1'b0;

    // R3 clamp low: 0 lines means 1
    cfg_burst_lines = 6'd0;
    read_line(24'h002000, "r3_zero");
    check(last_cmd_beats == 4, "R3 zero clamps to one line",
          64'(last_cmd_beats), 64'd4);
    idle(20);
    c0 = cmd_count;
    read_line(24'h002020, "r3_next");
    check(cmd_count - c0 == 1, "R3 one-line window misses next line",
          64'(cmd_count - c0), 64'd1);
    idle(20);

    // R3 clamp high: 45 lines means 32
    cfg_burst_lines = 6'd45;
    read_line(24'h008000, "r3_big");
    check(last_cmd_beats == 128, "R3 large value clamps to buffer",
          64'(last_cmd_beats), 64'd128);
    idle(200);
    c0 = cmd_count;
    read_line(24'h0083E0, "r4_top");
    check(cmd_count == c0, "R4 top line of full buffer hits",
          64'(cmd_count - c0), 64'd0);
    read_line(24'h008400, "r9_beyond");
    check(cmd_count - c0 == 1, "R9 line past full buffer misses",
          64'(cmd_count - c0), 64'd1);
    idle(200);

    // slow flash: early return, waiting hit, abort
    cfg_burst_lines = 6'd16;
    fm_gap = 3;
    read_line(24'h010000, "r6_first");
    check(fm_active === 1'b1 && fm_left > 0, "R6 burst still streaming after return",
          64'(fm_left), 64'd1);
    c0 = cmd_count;
    a0 = abort_count;
    toggle_ready = 1'b1;
    read_line(24'h010100, "r7_ahead");
    toggle_ready = 1'b0;
    check(cmd_count == c0 && abort_count == a0, "R7 wait without restart",
          64'(cmd_count - c0 + abort_count - a0), 64'd0);
    read_line(24'h020040, "r8_switch");
    check(abort_count - a0 == 1, "R8 abort pulse on mid-burst miss",
          64'(abort_count - a0), 64'd1);
    check(last_cmd_addr === 24'h020040 && cmd_count - c0 == 1,
          "R8 new command after abort", 64'(last_cmd_addr), 64'h020040);
    fm_gap = 0;
    idle(300);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule